// File: doc/BRIEF.md
# USB Host Pipe Control Logic

This block keeps the control state for the seven pipes of a USB host controller. For each pipe it holds a freeze flag that halts request generation, a data-toggle reset request, a FIFO ownership bit that passes one of two buffer banks between the packet engine and software, and two interrupt-enable bits. Software changes any bit only by writing ones into a per-pipe set-strobe word or clear-strobe word. It reads the current state back from a per-pipe control word.

The pipe engine reports protocol events to the block: a STALL handshake, an error level, each processed IN request, a bank becoming free, an IN packet being stored, the end of a toggle reset, and the pipe-reset and pipe-enable levels. The block returns a request-enable per pipe, the toggle-reset request, the current bank pointer, and a one-cycle pulse each time software hands a bank back.

Each pipe has two state machines. The freeze machine has the states `FRZ_RUN` and `FRZ_HALT`. It moves RUN to HALT on any freeze cause. It moves HALT to RUN on a freeze clear strobe, but only in a cycle with no freeze cause. The FIFO machine has the states `FIFO_ENGINE` (bit reads 0) and `FIFO_CPU` (bit reads 1). It moves ENGINE to CPU on the hardware fill/free event or on the set strobe. It moves CPU to ENGINE on the clear strobe, but only in a cycle with no set event. That CPU to ENGINE move also flips the bank pointer and pulses `bank_release`.

Top module: `usbh_pipe_ctrl`

## Requirements
- R1: Under reset every control word reads zero, and `dt_reset`, `bank_sel` and `bank_release` are zero.
- R2: Pipe p (0..6) is read at byte address 0x5C0+4p, its set strobe is at 0x5F0+4p and its clear strobe is at 0x620+4p. Writes to the read address have no effect. In the control word the bits are: bit 0 freeze, bit 1 toggle reset, bit 2 FIFO ownership, bit 3 busy-bank interrupt enable, bit 4 short-packet interrupt enable, bit 8 current bank. All other bits read zero.
- R3: A zero bit in a strobe word leaves the matching bit unchanged. A hardware set event in the same cycle as a software clear wins.
- R4: Freeze is set one cycle after any of these: the freeze set strobe, the pipe being unconfigured, a STALL pulse, the error level being high, or a rising edge of pipe reset or pipe enable.
- R5: A running pipe with programmed count N (8 bits per pipe) freezes on its N+1-th processed IN request. The request count restarts from zero when the freeze is cleared and on a pipe reset edge.
- R6: `req_en` of a pipe is high exactly when the pipe is configured and its freeze bit is 0.
- R7: The toggle-reset bit is set by its strobe and drives `dt_reset`. It clears one cycle after `dt_done`, unless a set strobe arrives in the same cycle.
- R8: For an OUT/SETUP pipe the FIFO bit is set by a bank-free event. For an IN pipe it is set by an IN-stored event. The event of the other direction is ignored.
- R9: A FIFO clear strobe while the FIFO bit is 1 and no set event is present clears the bit, flips `bank_sel`, and pulses `bank_release` for exactly one cycle. With the bit at 0 the bank does not change.
- R10: A pipe reset rising edge returns the bank pointer to 0.
- R11: The two interrupt-enable bits change only through their own set and clear strobes.
- R12: Edge detection is per pipe. A pipe reset or enable level that stays high does not freeze the pipe again after software clears the freeze.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Byte write address |
| wr_data | input | 5 | Write data (control field bits) |
| rd_addr | input | 12 | Byte read address |
| rd_data | output | 32 | Control word at rd_addr, zero if unmapped |
| pipe_cfg | input | 7 | Pipe configured, per pipe |
| pipe_is_in | input | 7 | 1 = IN pipe, 0 = OUT/SETUP pipe |
| ev_stall | input | 7 | STALL handshake received pulse |
| ev_err | input | 7 | Pipe error level |
| ev_in_req | input | 7 | One IN request processed pulse |
| in_req_num | input | 56 | Programmed IN request count, 8 bits per pipe |
| ev_bank_free | input | 7 | Current bank became free pulse |
| ev_in_stored | input | 7 | IN packet stored in current bank pulse |
| dt_done | input | 7 | Toggle reset carried out pulse |
| pipe_rst | input | 7 | Pipe reset level |
| pipe_en | input | 7 | Pipe enable level |
| req_en | output | 7 | Request generation allowed |
| dt_reset | output | 7 | Toggle reset request |
| bank_sel | output | 7 | Current bank pointer |
| bank_release | output | 7 | One-cycle bank hand-back pulse |

## Verification
Every state bit, `dt_reset` and `bank_sel` changes at the first clock edge after the write or event that causes it. `bank_release` is high for the cycle that follows that edge and drops at the next one. `req_en` and `rd_data` follow their inputs combinationally. The bench drives inputs just after the falling edge. A behavioural model updates on every rising edge, and all outputs are compared at the next falling edge, so each result is sampled in the cycle it is due. Directed read-backs are taken after the address has settled within that same cycle.

// File: rtl/usbh_pipe_pkg.sv
package usbh_pipe_pkg;
    localparam int CTRL_W   = 5;
    localparam int B_FRZ    = 0;
    localparam int B_DTR    = 1;
    localparam int B_FIFO   = 2;
    localparam int B_IEBUSY = 3;
    localparam int B_IESHRT = 4;
    localparam int B_BANK   = 8;

    typedef enum logic { FRZ_RUN = 1'b0, FRZ_HALT = 1'b1 } frz_state_t;
    typedef enum logic { FIFO_ENGINE = 1'b0, FIFO_CPU = 1'b1 } fifo_state_t;
endpackage

// File: rtl/usbh_edge_rise.sv
module usbh_edge_rise #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
endmodule

// File: rtl/usbh_reg_decode.sv
module usbh_reg_decode
    import usbh_pipe_pkg::*;
#(
    parameter int NUM_PIPES = 7,
    parameter int ADDR_W    = 12,
    parameter int SET_BASE  = 'h5F0,
    parameter int CLR_BASE  = 'h620
) (
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [CTRL_W-1:0]                wr_data,
    output logic [NUM_PIPES-1:0][CTRL_W-1:0] set_s,
    output logic [NUM_PIPES-1:0][CTRL_W-1:0] clr_s
);
    localparam int STRIDE = 4;

    for (genvar p = 0; p < NUM_PIPES; p++) begin : g_dec
        logic hit_set, hit_clr;
        assign hit_set  = wr_en && (wr_addr == ADDR_W'(SET_BASE + STRIDE * p));
        assign hit_clr  = wr_en && (wr_addr == ADDR_W'(CLR_BASE + STRIDE * p));
        assign set_s[p] = hit_set ? wr_data : '0;
        assign clr_s[p] = hit_clr ? wr_data : '0;
    end
endmodule

// File: rtl/usbh_pipe_slice.sv
module usbh_pipe_slice
    import usbh_pipe_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] set_s,
    input  logic [CTRL_W-1:0] clr_s,
    input  logic              cfg,
    input  logic              dir_in,
    input  logic              ev_stall,
    input  logic              ev_err,
    input  logic              ev_in_req,
    input  logic [CNT_W-1:0]  in_req_num,
    input  logic              ev_bank_free,
    input  logic              ev_in_stored,
    input  logic              dt_done,
    input  logic              rst_rise,
    input  logic              en_rise,
    output logic              frozen,
    output logic              dt_req,
    output logic              fifo_bit,
    output logic              ie_busy,
    output logic              ie_short,
    output logic              bank,
    output logic              bank_rel
);
    frz_state_t  frz_q, frz_d;
    fifo_state_t fifo_q, fifo_d;
    logic [CNT_W-1:0] req_cnt_q;
    logic hw_freeze, cnt_hit, frz_release;
    logic fifo_setev, bank_flip;
    logic dt_q, ieb_q, ies_q, bank_q, rel_q;

    // Freeze machine: next-state logic
    always_comb begin
        cnt_hit   = ev_in_req && (frz_q == FRZ_RUN) && (req_cnt_q == in_req_num);
        hw_freeze = set_s[B_FRZ] | ~cfg | ev_stall | ev_err | rst_rise | en_rise | cnt_hit;
        frz_d     = frz_q;
        unique case (frz_q)
            FRZ_RUN:  if (hw_freeze) frz_d = FRZ_HALT;
            FRZ_HALT: if (clr_s[B_FRZ] && !hw_freeze) frz_d = FRZ_RUN;
        endcase
        frz_release = (frz_q == FRZ_HALT) && (frz_d == FRZ_RUN);
    end

    // FIFO ownership machine: next-state logic
    always_comb begin
        fifo_setev = set_s[B_FIFO] | (dir_in ? ev_in_stored : ev_bank_free);
        fifo_d     = fifo_q;
        unique case (fifo_q)
            FIFO_ENGINE: if (fifo_setev) fifo_d = FIFO_CPU;
            FIFO_CPU:    if (clr_s[B_FIFO] && !fifo_setev) fifo_d = FIFO_ENGINE;
        endcase
        bank_flip = (fifo_q == FIFO_CPU) && (fifo_d == FIFO_ENGINE) && !rst_rise;
    end

    // State registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frz_q     <= FRZ_RUN;
            fifo_q    <= FIFO_ENGINE;
            req_cnt_q <= '0;
            dt_q      <= 1'b0;
            ieb_q     <= 1'b0;
            ies_q     <= 1'b0;
            bank_q    <= 1'b0;
            rel_q     <= 1'b0;
        end else begin
            frz_q  <= frz_d;
            fifo_q <= fifo_d;
            if (rst_rise || frz_release || cnt_hit) req_cnt_q <= '0;
            else if (ev_in_req && (frz_q == FRZ_RUN)) req_cnt_q <= req_cnt_q + 1'b1;
            if (set_s[B_DTR])         dt_q <= 1'b1;
            else if (dt_done)         dt_q <= 1'b0;
            if (set_s[B_IEBUSY])      ieb_q <= 1'b1;
            else if (clr_s[B_IEBUSY]) ieb_q <= 1'b0;
            if (set_s[B_IESHRT])      ies_q <= 1'b1;
            else if (clr_s[B_IESHRT]) ies_q <= 1'b0;
            if (rst_rise)             bank_q <= 1'b0;
            else if (bank_flip)       bank_q <= ~bank_q;
            rel_q <= bank_flip;
        end
    end

    // Outputs
    always_comb begin
        frozen   = (frz_q == FRZ_HALT);
        fifo_bit = (fifo_q == FIFO_CPU);
        dt_req   = dt_q;
        ie_busy  = ieb_q;
        ie_short = ies_q;
        bank     = bank_q;
        bank_rel = rel_q;
    end

    assert_stall_freezes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stall |=> frozen);
    assert_count_freezes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_hit |=> frozen);
    assert_dt_selfclear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dt_req && dt_done && !set_s[B_DTR]) |=> !dt_req);
    assert_release_flips_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bank_rel |-> (bank != $past(bank)));
    assert_reset_bank0_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_rise |=> (bank == 1'b0));
    assert_ie_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_s[B_IEBUSY] && !clr_s[B_IEBUSY]) |=> $stable(ie_busy));
endmodule

// File: rtl/usbh_pipe_ctrl.sv
module usbh_pipe_ctrl
    import usbh_pipe_pkg::*;
#(
    parameter int NUM_PIPES = 7,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 8,
    parameter int CTRL_BASE = 'h5C0,
    parameter int SET_BASE  = 'h5F0,
    parameter int CLR_BASE  = 'h620
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [CTRL_W-1:0]          wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [DATA_W-1:0]          rd_data,
    input  logic [NUM_PIPES-1:0]       pipe_cfg,
    input  logic [NUM_PIPES-1:0]       pipe_is_in,
    input  logic [NUM_PIPES-1:0]       ev_stall,
    input  logic [NUM_PIPES-1:0]       ev_err,
    input  logic [NUM_PIPES-1:0]       ev_in_req,
    input  logic [NUM_PIPES*CNT_W-1:0] in_req_num,
    input  logic [NUM_PIPES-1:0]       ev_bank_free,
    input  logic [NUM_PIPES-1:0]       ev_in_stored,
    input  logic [NUM_PIPES-1:0]       dt_done,
    input  logic [NUM_PIPES-1:0]       pipe_rst,
    input  logic [NUM_PIPES-1:0]       pipe_en,
    output logic [NUM_PIPES-1:0]       req_en,
    output logic [NUM_PIPES-1:0]       dt_reset,
    output logic [NUM_PIPES-1:0]       bank_sel,
    output logic [NUM_PIPES-1:0]       bank_release
);
    localparam int STRIDE = 4;

    logic [NUM_PIPES-1:0][CTRL_W-1:0] set_s, clr_s;
    logic [NUM_PIPES-1:0]             rst_rise, en_rise;
    logic [NUM_PIPES-1:0]             frozen, fifo_bit, ie_busy, ie_short;
    logic [NUM_PIPES-1:0][DATA_W-1:0] view;

    usbh_reg_decode #(
        .NUM_PIPES(NUM_PIPES), .ADDR_W(ADDR_W),
        .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
    ) u_dec (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .set_s(set_s), .clr_s(clr_s)
    );

    usbh_edge_rise #(.W(NUM_PIPES)) u_rst_edge (
        .clk(clk), .rst_n(rst_n), .lvl(pipe_rst), .rise(rst_rise));
    usbh_edge_rise #(.W(NUM_PIPES)) u_en_edge (
        .clk(clk), .rst_n(rst_n), .lvl(pipe_en), .rise(en_rise));

    for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
        usbh_pipe_slice #(.CNT_W(CNT_W)) u_slice (
            .clk(clk), .rst_n(rst_n),
            .set_s(set_s[p]), .clr_s(clr_s[p]),
            .cfg(pipe_cfg[p]), .dir_in(pipe_is_in[p]),
            .ev_stall(ev_stall[p]), .ev_err(ev_err[p]),
            .ev_in_req(ev_in_req[p]),
            .in_req_num(in_req_num[p*CNT_W +: CNT_W]),
            .ev_bank_free(ev_bank_free[p]), .ev_in_stored(ev_in_stored[p]),
            .dt_done(dt_done[p]),
            .rst_rise(rst_rise[p]), .en_rise(en_rise[p]),
            .frozen(frozen[p]), .dt_req(dt_reset[p]), .fifo_bit(fifo_bit[p]),
            .ie_busy(ie_busy[p]), .ie_short(ie_short[p]),
            .bank(bank_sel[p]), .bank_rel(bank_release[p])
        );

        always_comb begin
            view[p]           = '0;
            view[p][B_FRZ]    = frozen[p];
            view[p][B_DTR]    = dt_reset[p];
            view[p][B_FIFO]   = fifo_bit[p];
            view[p][B_IEBUSY] = ie_busy[p];
            view[p][B_IESHRT] = ie_short[p];
            view[p][B_BANK]   = bank_sel[p];
        end
    end

    assign req_en = pipe_cfg & ~frozen;

    always_comb begin
        rd_data = '0;
        for (int p = 0; p < NUM_PIPES; p++) begin
            if (rd_addr == ADDR_W'(CTRL_BASE + STRIDE * p)) rd_data = view[p];
        end
    end

    assert_unconfig_gates_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pipe_cfg[0]) |-> !req_en[0]);
endmodule

// File: tb/usbh_pipe_ctrl_test.sv
`timescale 1ns/1ps
module usbh_pipe_ctrl_test;
    localparam int N = 7;
    localparam int CTRL = 'h5C0, SETB = 'h5F0, CLRB = 'h620;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [11:0] wr_addr = '0, rd_addr = 12'h5C0;
    logic [4:0]  wr_data = '0;
    logic [31:0] rd_data;
    logic [N-1:0] pipe_cfg = '1, pipe_is_in = 7'b0001000;
    logic [N-1:0] ev_stall = '0, ev_err = '0, ev_in_req = '0, ev_bank_free = '0;
    logic [N-1:0] ev_in_stored = '0, dt_done = '0, pipe_rst = '0, pipe_en = '0;
    logic [N*8-1:0] in_req_num = 56'h2;
    logic [N-1:0] req_en, dt_reset, bank_sel, bank_release;

    int tests = 0, fails = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    usbh_pipe_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pipe_cfg(pipe_cfg), .pipe_is_in(pipe_is_in),
        .ev_stall(ev_stall), .ev_err(ev_err), .ev_in_req(ev_in_req), .in_req_num(in_req_num),
        .ev_bank_free(ev_bank_free), .ev_in_stored(ev_in_stored), .dt_done(dt_done),
        .pipe_rst(pipe_rst), .pipe_en(pipe_en), .req_en(req_en), .dt_reset(dt_reset),
        .bank_sel(bank_sel), .bank_release(bank_release));

    // Behavioural reference model
    int m_frz[N], m_dt[N], m_fifo[N], m_ieb[N], m_ies[N], m_bank[N], m_rel[N], m_cnt[N];
    int m_prst[N], m_pen[N];

    initial for (int p = 0; p < N; p++) begin
        m_frz[p] = 0; m_dt[p] = 0; m_fifo[p] = 0; m_ieb[p] = 0; m_ies[p] = 0;
        m_bank[p] = 0; m_rel[p] = 0; m_cnt[p] = 0; m_prst[p] = 0; m_pen[p] = 0;
    end

    always @(posedge clk) begin
        for (int p = 0; p < N; p++) begin
            int s, c, rr, re, hit, fset, nfrz, fev, rel;
            if (!rst_n) begin
                m_frz[p] = 0; m_dt[p] = 0; m_fifo[p] = 0; m_ieb[p] = 0; m_ies[p] = 0;
                m_bank[p] = 0; m_rel[p] = 0; m_cnt[p] = 0; m_prst[p] = 0; m_pen[p] = 0;
            end else begin
                s = (wr_en && wr_addr == 12'(SETB + 4*p)) ? int'(wr_data) : 0;
                c = (wr_en && wr_addr == 12'(CLRB + 4*p)) ? int'(wr_data) : 0;
                rr = (pipe_rst[p] && !m_prst[p]) ? 1 : 0;
                re = (pipe_en[p] && !m_pen[p]) ? 1 : 0;
                hit = (ev_in_req[p] && !m_frz[p] && m_cnt[p] == int'(in_req_num[p*8 +: 8])) ? 1 : 0;
                fset = ((s & 1) != 0 || !pipe_cfg[p] || ev_stall[p] || ev_err[p] || rr || re || hit) ? 1 : 0;
                nfrz = fset ? 1 : ((c & 1) != 0 ? 0 : m_frz[p]);
                if (rr || hit || (m_frz[p] && !nfrz)) m_cnt[p] = 0;
                else if (ev_in_req[p] && !m_frz[p]) m_cnt[p]++;
                m_frz[p] = nfrz;
                if (s & 2) m_dt[p] = 1; else if (dt_done[p]) m_dt[p] = 0;
                fev = ((s & 4) != 0 || (pipe_is_in[p] ? ev_in_stored[p] : ev_bank_free[p])) ? 1 : 0;
                rel = ((c & 4) != 0 && m_fifo[p] && !fev && !rr) ? 1 : 0;
                if (fev) m_fifo[p] = 1; else if (c & 4) m_fifo[p] = 0;
                if (rr) m_bank[p] = 0; else if (rel) m_bank[p] = 1 - m_bank[p];
                m_rel[p] = rel;
                if (s & 8) m_ieb[p] = 1; else if (c & 8) m_ieb[p] = 0;
                if (s & 16) m_ies[p] = 1; else if (c & 16) m_ies[p] = 0;
                m_prst[p] = pipe_rst[p]; m_pen[p] = pipe_en[p];
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (!finished) begin
        logic [N-1:0] e_req, e_dt, e_bank, e_rel;
        logic [31:0] e_rd;
        e_rd = '0;
        for (int p = 0; p < N; p++) begin
            e_req[p]  = pipe_cfg[p] && !m_frz[p];
            e_dt[p]   = m_dt[p] != 0;
            e_bank[p] = m_bank[p] != 0;
            e_rel[p]  = m_rel[p] != 0;
            if (rd_addr == 12'(CTRL + 4*p))
                e_rd = 32'(m_frz[p] | (m_dt[p] << 1) | (m_fifo[p] << 2) | (m_ieb[p] << 3)
                           | (m_ies[p] << 4) | (m_bank[p] << 8));
        end
        chk("R6 req_en model", 32'(req_en), 32'(e_req));
        chk("R7 dt_reset model", 32'(dt_reset), 32'(e_dt));
        chk("R9 bank_sel model", 32'(bank_sel), 32'(e_bank));
        chk("R9 bank_release model", 32'(bank_release), 32'(e_rel));
        chk("R2 rd_data model", rd_data, e_rd);
    end

    task automatic cyc();
        @(negedge clk); #1;
    endtask

    task automatic wr(input int addr, input logic [4:0] d);
        wr_en = 1'b1; wr_addr = 12'(addr); wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic rdchk(input int p, input string tag, input logic [31:0] exp);
        rd_addr = 12'(CTRL + 4*p);
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic inreq(input int p);
        ev_in_req[p] = 1'b1; cyc(); ev_in_req[p] = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        tests++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        cyc(); cyc();
        rdchk(0, "R1 reset word", 32'h0);
        rdchk(6, "R1 reset word", 32'h0);
        chk("R1 dt_reset", 32'(dt_reset), 0);
        chk("R1 bank_sel", 32'(bank_sel), 0);
        chk("R1 bank_release", 32'(bank_release), 0);
        rst_n = 1'b1;
        cyc();
        chk("R6 all running", 32'(req_en), 32'h7F);

        // interrupt enables, zero strobes, read-only word
        wr(SETB + 8, 5'h18); rdchk(2, "R11 ie set", 32'h18);
        wr(SETB + 8, 5'h00); rdchk(2, "R3 zero set", 32'h18);
        wr(CTRL + 8, 5'h1F); rdchk(2, "R2 ro write", 32'h18);
        wr(CLRB + 8, 5'h10); rdchk(2, "R11 ie clear", 32'h08);
        wr(CLRB + 8, 5'h08); rdchk(2, "R11 ie clear", 32'h00);

        // freeze sources
        ev_stall[1] = 1'b1; cyc(); ev_stall[1] = 1'b0;
        chk("R4 stall", 32'(req_en[1]), 0); rdchk(1, "R4 stall", 32'h1);
        wr(CLRB + 4, 5'h01); chk("R6 resume", 32'(req_en[1]), 1);
        ev_err[3] = 1'b1; cyc();
        wr(CLRB + 12, 5'h01); rdchk(3, "R3 hw over clear", 32'h1);
        ev_err[3] = 1'b0;
        wr(CLRB + 12, 5'h01); rdchk(3, "R4 err released", 32'h0);
        pipe_cfg[4] = 1'b0; cyc();
        chk("R6 unconfigured", 32'(req_en[4]), 0); rdchk(4, "R4 unconfigured", 32'h1);
        pipe_cfg[4] = 1'b1; wr(CLRB + 16, 5'h01); rdchk(4, "R4 cfg restored", 32'h0);
        wr(SETB + 16, 5'h01); rdchk(4, "R4 set strobe", 32'h1);
        wr(CLRB + 16, 5'h01);

        // edges of pipe reset and pipe enable
        pipe_rst[5] = 1'b1; cyc(); rdchk(5, "R4 reset edge", 32'h1);
        wr(CLRB + 20, 5'h01); rdchk(5, "R12 level held", 32'h0);
        cyc(); rdchk(5, "R12 level held", 32'h0);
        pipe_rst[5] = 1'b0; pipe_en[5] = 1'b1; cyc();
        rdchk(5, "R4 enable edge", 32'h1);
        wr(CLRB + 20, 5'h01); rdchk(5, "R12 enable held", 32'h0);

        // IN request count, limit 2 on pipe 0
        inreq(0); inreq(0); rdchk(0, "R5 below limit", 32'h0);
        inreq(0); rdchk(0, "R5 limit+1", 32'h1);
        wr(CLRB, 5'h01);
        inreq(0); inreq(0); rdchk(0, "R5 restarted", 32'h0);
        inreq(0); rdchk(0, "R5 limit+1 again", 32'h1);
        wr(CLRB, 5'h01);

        // toggle reset
        wr(SETB + 24, 5'h02);
        chk("R7 dt set", 32'(dt_reset[6]), 1); rdchk(6, "R7 dt bit", 32'h2);
        dt_done[6] = 1'b1; cyc(); dt_done[6] = 1'b0;
        chk("R7 dt self clear", 32'(dt_reset[6]), 0);

        // FIFO handshake, OUT pipe 0
        ev_in_stored[0] = 1'b1; cyc(); ev_in_stored[0] = 1'b0;
        rdchk(0, "R8 wrong dir ignored", 32'h0);
        ev_bank_free[0] = 1'b1; cyc(); ev_bank_free[0] = 1'b0;
        rdchk(0, "R8 bank free", 32'h4);
        wr(CLRB, 5'h04);
        chk("R9 release pulse", 32'(bank_release[0]), 1);
        chk("R9 bank flip", 32'(bank_sel[0]), 1);
        rdchk(0, "R9 word", 32'h100);
        cyc(); chk("R9 pulse one cycle", 32'(bank_release[0]), 0);
        wr(CLRB, 5'h04); rdchk(0, "R9 no flip when clear", 32'h100);
        ev_bank_free[0] = 1'b1; wr(CLRB, 5'h04); ev_bank_free[0] = 1'b0;
        rdchk(0, "R8 hw set wins", 32'h104);
        wr(CLRB, 5'h04); rdchk(0, "R9 flip back", 32'h000);
        ev_bank_free[0] = 1'b1; cyc(); ev_bank_free[0] = 1'b0;
        wr(CLRB, 5'h04); rdchk(0, "R9 flip to 1", 32'h100);

        // IN pipe 3
        ev_bank_free[3] = 1'b1; cyc(); ev_bank_free[3] = 1'b0;
        rdchk(3, "R8 IN ignores free", 32'h0);
        ev_in_stored[3] = 1'b1; cyc(); ev_in_stored[3] = 1'b0;
        rdchk(3, "R8 IN stored", 32'h4);

        // pipe reset returns bank
        pipe_rst[0] = 1'b1; cyc(); pipe_rst[0] = 1'b0;
        chk("R10 bank zero", 32'(bank_sel[0]), 0);
        rdchk(0, "R10 word", 32'h1);

        cyc(); cyc();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule